// File: doc/BRIEF.md
# Register-Mapped Serial Port with Sticky Status

This block is a full-duplex asynchronous serial port that a processor reaches through four word registers: received character, character to send, status, and bit-rate divisor. The character has 5 to 8 data bits, which is a parameter. Parity can be left out, or added as odd or even parity. Every frame has one start bit and one stop bit.

Each direction has one character buffer. A character written while the transmitter is still busy replaces the one that is waiting. Errors on the receive side set sticky status flags. Reading the status register clears them. A character whose stop bit is wrong is dropped. A character that arrives while the previous one has not been read is also dropped.

The transmitter counts whole bit periods. The receiver uses a tick at sixteen times the bit rate and samples each bit at its centre. Three single-cycle event outputs mark a character stored, a character sent and an error detected.

Top module: `sio_uart`

## Requirements
- R1: After reset the status register reads 0, the receive register reads 0, `txd` is 1, and the divisor register holds CLK_HZ/(16*BAUD_RATE)-1.
- R2: A transmitted frame is sent in this order: a 0 start bit, then DATA_BITS data bits with the least significant bit first, then the parity bit if parity is enabled, then a 1 stop bit. Odd parity makes the total count of ones in the data and parity bits odd. Even parity makes that count even. Each bit lasts (divisor+1)*16 clock cycles. The line goes low on the second edge after the write. When the port is idle, `txd` stays at 1.
- R3: Status bit 3 is 1 from the write of the transmit register (select 1) until the frame has finished. A write made while a character is still waiting replaces that waiting character.
- R4: Reading the transmit register returns 0. Writes to the receive register (select 0) and to the status register (select 2) change nothing.
- R5: A good frame stores its data in the receive register and sets status bit 0. Reading the receive register clears bit 0. Reading it again returns the same data.
- R6: A parity mismatch sets status bit 7, and the character is still stored.
- R7: A stop bit sampled as 0 sets status bit 6 and drops the character.
- R8: A frame that completes while bit 0 is set sets status bit 5 and drops the new character. The older data is kept.
- R9: Bits 7, 6 and 5 of the status register stay set until the status register is read. All other status bits read 0.
- R10: `irq_rx` pulses for one cycle for each stored character. `irq_tx` pulses for one cycle when a stop bit ends. `irq_err` pulses for one cycle for each detected error.
- R11: The divisor register (select 3) is 20 bits wide. Bits 31:20 read back as 0.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd`. In every other cycle `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 receive, 1 transmit, 2 status, 3 divisor |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_rx | output | 1 | Character stored event |
| irq_tx | output | 1 | Character sent event |
| irq_err | output | 1 | Receive error event |

## Verification
The bench builds the port with 7 data bits and odd parity, a 16 MHz clock parameter and a 1 Mbaud default. This reset divisor is 0, so a bit lasts 16 cycles and many frames fit into a short run. Partway through, the bench programs the divisor to 2, which gives 48-cycle bits, so the transmit and receive paths are also exercised at a rate other than the reset rate. The 7-bit width means the parity and alignment paths are checked with a character narrower than the byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] SEL_RXD  = 2'd0;
  localparam logic [1:0] SEL_TXD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_BAUD = 2'd3;
  localparam int BAUD_W = 20;

  typedef struct packed {
    logic store;
    logic par_err;
    logic frm_err;
    logic ovr_err;
  } rx_evt_t;

  function automatic logic calc_par(input logic [7:0] d, input int unsigned nbits,
                                    input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < nbits) p = p ^ d[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/sio_tick16.sv
module sio_tick16 #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    tick_d = 1'b0;
    if (cnt_q >= div) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int   DATA_BITS = 8,
  parameter bit   PAR_EN    = 1'b0,
  parameter bit   PAR_ODD   = 1'b0,
  parameter int   CW        = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] bit_cycles,
  input  logic          load,
  input  logic [7:0]    ldata,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
  localparam logic [2:0] LAST_IDX = 3'(DATA_BITS - 1);

  tx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          par_q, par_d;
  logic          txd_d, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    txd_d  = txd;
    done_d = 1'b0;
    if (st_q == TX_IDLE) begin
      if (load) begin
        st_d  = TX_START;
        cnt_d = bit_cycles - 1'b1;
        sh_d  = ldata;
        par_d = sio_pkg::calc_par(ldata, DATA_BITS, PAR_ODD);
        txd_d = 1'b0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = bit_cycles - 1'b1;
      case (st_q)
        TX_START: begin
          st_d  = TX_DATA;
          idx_d = '0;
          txd_d = sh_q[0];
        end
        TX_DATA: begin
          if (idx_q == LAST_IDX) begin
            if (PAR_EN) begin
              st_d  = TX_PAR;
              txd_d = par_q;
            end else begin
              st_d  = TX_STOP;
              txd_d = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            sh_d  = {1'b0, sh_q[7:1]};
            txd_d = sh_q[1];
          end
        end
        TX_PAR: begin
          st_d  = TX_STOP;
          txd_d = 1'b1;
        end
        default: begin
          st_d   = TX_IDLE;
          txd_d  = 1'b1;
          done_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      txd   <= 1'b1;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      txd   <= txd_d;
      done  <= done_d;
    end
  end

  assign busy = (st_q != TX_IDLE);

  // R2: the line rests high while no frame is in flight
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_IDLE) |-> txd);
  // R10: the completion event lasts one cycle
  a_r10_tx_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: a load while idle starts with a low start bit
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st_q == TX_IDLE) |=> !txd);
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_BITS = 8,
  parameter bit PAR_EN    = 1'b0,
  parameter bit PAR_ODD   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic             rx_full,
  output sio_pkg::rx_evt_t evt,
  output logic [7:0]       data
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rx_st_e;
  localparam int         ALIGN    = 8 - DATA_BITS;
  localparam logic [2:0] LAST_IDX = 3'(DATA_BITS - 1);

  rx_st_e           st_q, st_d;
  logic [1:0]       sync_q;
  logic [3:0]       tc_q, tc_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       sh_q, sh_d;
  logic             pbit_q, pbit_d;
  sio_pkg::rx_evt_t evt_d;
  logic             rx_s;

  assign rx_s = sync_q[1];
  assign data = sh_q >> ALIGN;

  always_comb begin
    st_d   = st_q;
    tc_d   = tc_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    evt_d  = '0;
    if (st_q == RX_WAITHI) begin
      if (rx_s) st_d = RX_IDLE;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rx_s) begin
            st_d = RX_START;
            tc_d = '0;
          end
        end
        RX_START: begin
          if (tc_q == 4'd7) begin
            tc_d  = '0;
            idx_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        RX_DATA: begin
          tc_d = tc_q + 1'b1;
          if (tc_q == 4'd15) begin
            sh_d = {rx_s, sh_q[7:1]};
            if (idx_q == LAST_IDX) st_d = PAR_EN ? RX_PAR : RX_STOP;
            else idx_d = idx_q + 1'b1;
          end
        end
        RX_PAR: begin
          tc_d = tc_q + 1'b1;
          if (tc_q == 4'd15) begin
            pbit_d = rx_s;
            st_d   = RX_STOP;
          end
        end
        default: begin
          tc_d = tc_q + 1'b1;
          if (tc_q == 4'd15) begin
            if (!rx_s) begin
              evt_d.frm_err = 1'b1;
              st_d          = RX_WAITHI;
            end else begin
              st_d = RX_IDLE;
              if (rx_full) begin
                evt_d.ovr_err = 1'b1;
              end else begin
                evt_d.store   = 1'b1;
                evt_d.par_err = PAR_EN &&
                  (pbit_q != sio_pkg::calc_par(data, DATA_BITS, PAR_ODD));
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sync_q <= 2'b11;
      tc_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      evt    <= '0;
    end else begin
      st_q   <= st_d;
      sync_q <= {sync_q[0], rxd};
      tc_q   <= tc_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
      evt    <= evt_d;
    end
  end

  // R7, R8: a dropped frame never also stores
  a_r7_drop_or_store: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.store, evt.frm_err, evt.ovr_err}));
  // R8: overrun only reported while the buffer is occupied
  a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_STOP && tick && tc_q == 4'd15 && rx_s && !rx_full) |=> !evt.ovr_err);
endmodule

// File: rtl/sio_uart.sv
module sio_uart #(
  parameter int DATA_BITS = 8,
  parameter bit PAR_EN    = 1'b0,
  parameter bit PAR_ODD   = 1'b0,
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD_RATE = 115_200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_err
);
  import sio_pkg::*;

  localparam int                BW       = BAUD_W;
  localparam int                CW       = BW + 5;
  localparam logic [BW-1:0]     BAUD_RST = BW'(CLK_HZ / (16 * BAUD_RATE) - 1);

  logic [BW-1:0] baud_q, baud_d;
  logic [7:0]    hold_q, hold_d;
  logic          full_q, full_d;
  logic [7:0]    rdat_q, rdat_d;
  logic          rval_q, rval_d;
  logic          perr_q, perr_d, ferr_q, ferr_d, oerr_q, oerr_d;
  logic [31:0]   rdata_d;
  logic [CW-1:0] bit_cycles;
  logic          tick, tx_busy, tx_done, tx_load;
  logic [7:0]    rx_word;
  rx_evt_t       evt;
  logic          wr_txd, wr_baud, rd_rxd, rd_stat;
  logic          unused_wbits;

  assign unused_wbits = ^reg_wdata[31:BW];
  assign wr_txd  = reg_wr && (reg_sel == SEL_TXD);
  assign wr_baud = reg_wr && (reg_sel == SEL_BAUD);
  assign rd_rxd  = reg_rd && (reg_sel == SEL_RXD);
  assign rd_stat = reg_rd && (reg_sel == SEL_STAT);
  assign bit_cycles = ({5'b0, baud_q} + 1'b1) << 4;
  assign tx_load = full_q && !tx_busy;

  sio_tick16 #(.DIV_W(BW)) tick_i (
    .clk(clk), .rst_n(rst_n), .div(baud_q), .tick(tick)
  );

  sio_tx #(.DATA_BITS(DATA_BITS), .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD), .CW(CW)) tx_i (
    .clk(clk), .rst_n(rst_n), .bit_cycles(bit_cycles), .load(tx_load),
    .ldata(hold_q), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sio_rx #(.DATA_BITS(DATA_BITS), .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_full(rval_q),
    .evt(evt), .data(rx_word)
  );

  always_comb begin
    baud_d = wr_baud ? reg_wdata[BW-1:0] : baud_q;
    hold_d = wr_txd ? reg_wdata[7:0] : hold_q;
    full_d = wr_txd ? 1'b1 : (tx_load ? 1'b0 : full_q);
    rdat_d = evt.store ? rx_word : rdat_q;
    rval_d = evt.store ? 1'b1 : (rd_rxd ? 1'b0 : rval_q);
    perr_d = evt.par_err ? 1'b1 : (rd_stat ? 1'b0 : perr_q);
    ferr_d = evt.frm_err ? 1'b1 : (rd_stat ? 1'b0 : ferr_q);
    oerr_d = evt.ovr_err ? 1'b1 : (rd_stat ? 1'b0 : oerr_q);
    rdata_d = '0;
    if (reg_rd) begin
      case (reg_sel)
        SEL_RXD:  rdata_d = {24'b0, rdat_q};
        SEL_STAT: rdata_d = {24'b0, perr_q, ferr_q, oerr_q, 1'b0,
                             full_q | tx_busy, 2'b0, rval_q};
        SEL_BAUD: rdata_d = {{(32-BW){1'b0}}, baud_q};
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q    <= BAUD_RST;
      hold_q    <= '0;
      full_q    <= 1'b0;
      rdat_q    <= '0;
      rval_q    <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      oerr_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      baud_q    <= baud_d;
      hold_q    <= hold_d;
      full_q    <= full_d;
      rdat_q    <= rdat_d;
      rval_q    <= rval_d;
      perr_q    <= perr_d;
      ferr_q    <= ferr_d;
      oerr_q    <= oerr_d;
      reg_rdata <= rdata_d;
    end
  end

  assign irq_rx  = evt.store;
  assign irq_tx  = tx_done;
  assign irq_err = evt.par_err | evt.frm_err | evt.ovr_err;

  // R12: no read, no data
  a_r12_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));
  // R9: a status read with no new error leaves all sticky flags clear
  a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !irq_err) |=> !(perr_q | ferr_q | oerr_q));
  // R5: reading the receive register drops the valid flag
  a_r5_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !evt.store) |=> !rval_q);
  // R7, R8: dropped frames leave the stored character alone
  a_r8_keep_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frm_err || evt.ovr_err) |=> $stable(rdat_q));
  // R11: upper divisor bits never read back set
  a_r11_baud_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_BAUD) |=> (reg_rdata[31:BW] == '0));
endmodule

// File: tb/sio_uart_tb_top.sv
`timescale 1ns/1ps
module sio_uart_tb_top;
  localparam int NB = 7;
  localparam int NFRAME = NB + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq_rx, irq_tx, irq_err;

  int n_checks = 0, n_fails = 0;
  int bitcyc = 16;
  int rx_pulses = 0, err_pulses = 0, tx_pulses = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  sio_uart #(.DATA_BITS(NB), .PAR_EN(1'b1), .PAR_ODD(1'b1),
             .CLK_HZ(16_000_000), .BAUD_RATE(1_000_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
  );

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d[NB-1:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural transmit model: pending slot, frame image, elapsed cycles
  logic        m_busy = 1'b0, m_pend = 1'b0, m_irq = 1'b0;
  logic [7:0]  m_hold = '0;
  logic [NFRAME-1:0] m_frame = '1;
  int          m_k = 0, m_bc = 16;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_pend = 1'b0; m_irq = 1'b0; m_k = 0;
    end else begin
      m_irq = 1'b0;
      if (m_busy) begin
        m_k++;
        if (m_k == NFRAME * m_bc) begin m_busy = 1'b0; m_irq = 1'b1; end
      end else if (m_pend) begin
        m_busy = 1'b1; m_k = 0; m_pend = 1'b0; m_bc = bitcyc;
        m_frame = {1'b1, odd_par(m_hold), m_hold[NB-1:0], 1'b0};
      end
      if (reg_wr && reg_sel == 2'd1) begin m_pend = 1'b1; m_hold = reg_wdata[7:0]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 txd", {31'b0, txd}, {31'b0, m_busy ? m_frame[m_k / m_bc] : 1'b1});
      check("R10 irq_tx", {31'b0, irq_tx}, {31'b0, m_irq});
      if (irq_rx) rx_pulses++;
      if (irq_err) err_pulses++;
      if (irq_tx) tx_pulses++;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    @(negedge clk);
    rxd = 1'b0; repeat (bitcyc) @(negedge clk);
    for (int i = 0; i < NB; i++) begin rxd = d[i]; repeat (bitcyc) @(negedge clk); end
    rxd = odd_par(d) ^ bad_par; repeat (bitcyc) @(negedge clk);
    rxd = ~bad_stop; repeat (bitcyc) @(negedge clk);
    rxd = 1'b1; repeat (2 * bitcyc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle rdata", reg_rdata, 32'h0);
    rd(2'd2, rv); check("R1 status", rv, 32'h0);
    rd(2'd3, rv); check("R1 baud reset", rv, 32'h0);
    rd(2'd0, rv); check("R1 rx data", rv, 32'h0);

    wr(2'd1, 32'h55);
    rd(2'd2, rv); check("R3 tx in use", rv, 32'h08);
    repeat (200) @(negedge clk);
    rd(2'd2, rv); check("R3 tx released", rv, 32'h0);
    check("R10 tx pulses", tx_pulses, 1);

    wr(2'd1, 32'h12);
    repeat (20) @(negedge clk);
    wr(2'd1, 32'h34);
    wr(2'd1, 32'h4B);
    repeat (400) @(negedge clk);
    check("R3 overwrite pulses", tx_pulses, 3);
    rd(2'd1, rv); check("R4 tx reads zero", rv, 32'h0);

    send_rx(8'h3A, 1'b0, 1'b0);
    check("R10 rx pulse", rx_pulses, 1);
    rd(2'd2, rv); check("R5 valid set", rv, 32'h01);
    rd(2'd0, rv); check("R5 data", rv, 32'h3A);
    rd(2'd2, rv); check("R5 valid cleared", rv, 32'h0);
    rd(2'd0, rv); check("R5 reread", rv, 32'h3A);
    wr(2'd0, 32'h7F);
    wr(2'd2, 32'hFF);
    rd(2'd2, rv); check("R4 status unchanged", rv, 32'h0);
    rd(2'd0, rv); check("R4 rx unchanged", rv, 32'h3A);

    send_rx(8'h21, 1'b1, 1'b0);
    check("R10 err pulse parity", err_pulses, 1);
    rd(2'd2, rv); check("R6 parity flag", rv, 32'h81);
    rd(2'd0, rv); check("R6 stored anyway", rv, 32'h21);
    rd(2'd2, rv); check("R9 cleared by read", rv, 32'h0);

    send_rx(8'h11, 1'b0, 1'b1);
    check("R7 no rx pulse", rx_pulses, 2);
    rd(2'd2, rv); check("R7 frame flag", rv, 32'h40);
    rd(2'd0, rv); check("R7 dropped", rv, 32'h21);
    rd(2'd2, rv); check("R9 frame cleared", rv, 32'h0);

    send_rx(8'h05, 1'b0, 1'b0);
    send_rx(8'h06, 1'b0, 1'b0);
    rd(2'd2, rv); check("R8 overrun flag", rv, 32'h21);
    rd(2'd0, rv); check("R8 old data kept", rv, 32'h05);
    check("R10 err pulses", err_pulses, 3);

    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, rv); check("R11 baud width", rv, 32'h000F_FFFF);
    wr(2'd3, 32'h2);
    bitcyc = 48;
    rd(2'd3, rv); check("R11 baud value", rv, 32'h2);
    wr(2'd1, 32'h6C);
    repeat (NFRAME * 48 + 20) @(negedge clk);
    check("R2 slow frame done", tx_pulses, 4);
    send_rx(8'h19, 1'b0, 1'b0);
    rd(2'd0, rv); check("R5 slow rx data", rv, 32'h19);
    repeat (3) @(negedge clk);
    check("R12 rdata after read", reg_rdata, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule